// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block moves a system out of its running state (NORMAL) into one of four low-power states and brings it back. These states are IDLE, STOP, DEEP-STOP and SLEEP. Software programs two registers over a simple synchronous bus: a mode-request register (`MODE`) and a configuration register (`CFG`). A legal mode request moves the state machine at once. A standby-for-interrupt input can also move it into IDLE when configuration allows it. A vector of wakeup requests returns it to NORMAL.

The configuration register sets four things: whether a STOP request lands in DEEP-STOP, whether the standby input may start IDLE, and whether wakeups in SLEEP need the battery-fault input. It also sets whether an internally generated reset reaches the flash-controller reset output. The block reports its current state and gives a one-cycle entry strobe for each low-power state.

The state machine has five named states: NORMAL, IDLE, STOP, DEEP-STOP and SLEEP. Its transitions are:
- stop-entry: NORMAL to STOP or DEEP-STOP.
- sleep-entry: NORMAL to SLEEP.
- standby-entry: NORMAL to IDLE.
- wake-return: any low-power state to NORMAL.

Top module: `lpc_ctrl`

## Requirements
- R1: After reset, `state_o` is NORMAL (code 0), `entry_pulse_o` is 0, and both registers read 0x0000_0000.
- R2: A write to `MODE` with bit 16 set and bits [15:0] not equal to 0x2BED takes stop-entry on the same clock edge. If `CFG` bit 16 was 0 before that write, the new state is STOP (code 2). The write value is stored.
- R3: A write to `MODE` with bits [15:0] equal to 0x2BED and bit 16 clear takes sleep-entry to SLEEP (code 4). Any other value with bit 16 clear, such as 0x2BEC or 0x1234, is stored but changes no state.
- R4: A `MODE` write with bit 16 set and bits [15:0] equal to 0x2BED is dropped: the state stays NORMAL and `MODE` keeps its previous value.
- R5: If `CFG` bit 16 is already 1 when STOP is requested, the new state is DEEP-STOP (code 3) instead of STOP.
- R6: In NORMAL with no register write, `standby_i`=1 takes standby-entry to IDLE (code 1) only when `CFG` bit 17 is 1. When that bit is 0, `standby_i` has no effect.
- R7: In SLEEP, a wakeup request causes wake-return only when `batt_flt_i`=1 or `CFG` bit 15 is 1. Otherwise the state stays SLEEP.
- R8: In IDLE, STOP or DEEP-STOP, any set bit of `wake_i` causes wake-return to NORMAL on the next clock edge and clears `MODE` to 0. In NORMAL, `wake_i` has no effect.
- R9: `flash_rst_o` equals `int_rst_i` while `CFG` bit 9 is 0, and stays 0 while that bit is 1.
- R10: Reserved bits read as 0 and ignore writes. For `MODE`, only bits [16:0] are stored. For `CFG`, only bits 17, 16, 15 and 9 are stored.
- R11: Register writes made while the state is not NORMAL are dropped.
- R12: On each entry into a low-power state, exactly one bit of `entry_pulse_o` is high for one cycle: bit 0 for IDLE, bit 1 for STOP, bit 2 for DEEP-STOP, bit 3 for SLEEP. It is high in the first cycle that `state_o` shows the new state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | ADDR_W | Register address (MODE_ADDR or CFG_ADDR) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register (combinational) |
| standby_i | input | 1 | Standby-for-interrupt indication |
| batt_flt_i | input | 1 | Battery-fault input that gates wakeup in SLEEP |
| wake_i | input | WAKE_W | Wakeup-source requests |
| int_rst_i | input | 1 | Internally generated reset |
| flash_rst_o | output | 1 | Flash-controller reset |
| state_o | output | 3 | Current state: 0 NORMAL, 1 IDLE, 2 STOP, 3 DEEP-STOP, 4 SLEEP |
| entry_pulse_o | output | 4 | One-cycle entry strobes (IDLE, STOP, DEEP-STOP, SLEEP) |

## Verification
The bench builds the controller with a 4-bit address, `MODE` at address 0, `CFG` at address 4, and a 3-bit wakeup vector. These values keep every state reachable through a few bus writes. The narrow wakeup vector lets the bench show that the lowest and the highest wakeup bit each cause wake-return, and that an unmapped address reads 0. The SLEEP gating is exercised against both the battery-fault input and the configuration override. Both orderings of the deep-stop configuration write are covered.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

    typedef enum logic [2:0] {
        ST_NORMAL = 3'd0,
        ST_IDLE   = 3'd1,
        ST_STOP   = 3'd2,
        ST_DSTOP  = 3'd3,
        ST_SLEEP  = 3'd4
    } lpc_state_e;

    localparam int DATA_W   = 32;
    localparam int MODE_W   = 17;
    localparam int STOP_BIT = 16;
    localparam int KEY_W    = 16;

    localparam int CFG_IDLE_BIT  = 17;
    localparam int CFG_DEEP_BIT  = 16;
    localparam int CFG_SWAKE_BIT = 15;
    localparam int CFG_FLASH_BIT = 9;

    localparam int PULSE_W = 4;

endpackage

// File: rtl/lpc_regs.sv
module lpc_regs
    import lpc_pkg::*;
#(
    parameter int          ADDR_W    = 4,
    parameter int          MODE_ADDR = 0,
    parameter int          CFG_ADDR  = 4,
    parameter logic [15:0] SLEEP_KEY = 16'h2BED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              accept,
    input  logic              wake_clear,
    output logic [DATA_W-1:0] rdata,
    output logic              stop_req,
    output logic              sleep_req,
    output logic              cfg_idle,
    output logic              cfg_deep,
    output logic              cfg_swake,
    output logic              cfg_flash
);

    logic [MODE_W-1:0] mode_q;
    logic              mode_hit, cfg_hit, key_match, stop_bit, conflict, mode_wr;
    logic              unused_wbits;

    assign mode_hit  = we && accept && (addr == ADDR_W'(MODE_ADDR));
    assign cfg_hit   = we && accept && (addr == ADDR_W'(CFG_ADDR));
    assign key_match = (wdata[KEY_W-1:0] == SLEEP_KEY);
    assign stop_bit  = wdata[STOP_BIT];
    assign conflict  = key_match && stop_bit;
    assign mode_wr   = mode_hit && !conflict;
    assign stop_req  = mode_wr && stop_bit;
    assign sleep_req = mode_wr && key_match;

    assign unused_wbits = ^{wdata[DATA_W-1:18], wdata[14:10], wdata[8:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (wake_clear) begin
            mode_q <= '0;
        end else if (mode_wr) begin
            mode_q <= wdata[MODE_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_idle  <= 1'b0;
            cfg_deep  <= 1'b0;
            cfg_swake <= 1'b0;
            cfg_flash <= 1'b0;
        end else if (cfg_hit) begin
            cfg_idle  <= wdata[CFG_IDLE_BIT];
            cfg_deep  <= wdata[CFG_DEEP_BIT];
            cfg_swake <= wdata[CFG_SWAKE_BIT];
            cfg_flash <= wdata[CFG_FLASH_BIT];
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(MODE_ADDR)) begin
            rdata[MODE_W-1:0] = mode_q;
        end else if (addr == ADDR_W'(CFG_ADDR)) begin
            rdata[CFG_IDLE_BIT]  = cfg_idle;
            rdata[CFG_DEEP_BIT]  = cfg_deep;
            rdata[CFG_SWAKE_BIT] = cfg_swake;
            rdata[CFG_FLASH_BIT] = cfg_flash;
        end
    end

endmodule

// File: rtl/lpc_wake.sv
module lpc_wake
    import lpc_pkg::*;
#(
    parameter int WAKE_W = 8
) (
    input  lpc_state_e        state,
    input  logic [WAKE_W-1:0] wake,
    input  logic              batt_flt,
    input  logic              cfg_swake,
    output logic              wake_ok
);

    logic any_req;
    assign any_req = |wake;

    always_comb begin
        wake_ok = 1'b0;
        unique case (state)
            ST_NORMAL: wake_ok = 1'b0;
            ST_IDLE,
            ST_STOP,
            ST_DSTOP:  wake_ok = any_req;
            ST_SLEEP:  wake_ok = any_req && (batt_flt || cfg_swake);
            default:   wake_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/lpc_fsm.sv
module lpc_fsm
    import lpc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stop_req,
    input  logic               sleep_req,
    input  logic               cfg_deep,
    input  logic               cfg_idle,
    input  logic               standby,
    input  logic               wake_ok,
    output lpc_state_e         state,
    output logic [PULSE_W-1:0] entry_pulse
);

    lpc_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_NORMAL: begin
                if (stop_req)                 state_nx = cfg_deep ? ST_DSTOP : ST_STOP;
                else if (sleep_req)           state_nx = ST_SLEEP;
                else if (standby && cfg_idle) state_nx = ST_IDLE;
            end
            ST_IDLE, ST_STOP, ST_DSTOP, ST_SLEEP: begin
                if (wake_ok) state_nx = ST_NORMAL;
            end
            default: state_nx = ST_NORMAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_NORMAL;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            entry_pulse <= '0;
        end else begin
            entry_pulse <= '0;
            if (state == ST_NORMAL) begin
                unique case (state_nx)
                    ST_IDLE:  entry_pulse <= 4'b0001;
                    ST_STOP:  entry_pulse <= 4'b0010;
                    ST_DSTOP: entry_pulse <= 4'b0100;
                    ST_SLEEP: entry_pulse <= 4'b1000;
                    default:  entry_pulse <= '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/lpc_ctrl.sv
module lpc_ctrl
    import lpc_pkg::*;
#(
    parameter int          ADDR_W    = 4,
    parameter int          MODE_ADDR = 0,
    parameter int          CFG_ADDR  = 4,
    parameter int          WAKE_W    = 8,
    parameter logic [15:0] SLEEP_KEY = 16'h2BED
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               standby_i,
    input  logic               batt_flt_i,
    input  logic [WAKE_W-1:0]  wake_i,
    input  logic               int_rst_i,
    output logic               flash_rst_o,
    output logic [2:0]         state_o,
    output logic [3:0]         entry_pulse_o
);

    lpc_state_e state;
    logic stop_req, sleep_req, cfg_idle, cfg_deep, cfg_swake, cfg_flash, wake_ok;

    lpc_regs #(
        .ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR), .CFG_ADDR(CFG_ADDR), .SLEEP_KEY(SLEEP_KEY)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .accept(state == ST_NORMAL), .wake_clear(wake_ok), .rdata(reg_rdata),
        .stop_req(stop_req), .sleep_req(sleep_req), .cfg_idle(cfg_idle),
        .cfg_deep(cfg_deep), .cfg_swake(cfg_swake), .cfg_flash(cfg_flash)
    );

    lpc_wake #(.WAKE_W(WAKE_W)) u_wake (
        .state(state), .wake(wake_i), .batt_flt(batt_flt_i),
        .cfg_swake(cfg_swake), .wake_ok(wake_ok)
    );

    lpc_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .sleep_req(sleep_req),
        .cfg_deep(cfg_deep), .cfg_idle(cfg_idle), .standby(standby_i),
        .wake_ok(wake_ok), .state(state), .entry_pulse(entry_pulse_o)
    );

    assign state_o     = state;
    assign flash_rst_o = int_rst_i && !cfg_flash;

endmodule

// File: rtl/lpc_ctrl_checker.sv
module lpc_ctrl_checker #(
    parameter int WAKE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic              standby_i,
    input logic              batt_flt_i,
    input logic [WAKE_W-1:0] wake_i,
    input logic              int_rst_i,
    input logic              flash_rst_o,
    input logic [2:0]        state_o,
    input logic [3:0]        entry_pulse_o,
    input logic              cfg_idle,
    input logic              cfg_swake
);

    assert_pulse_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(entry_pulse_o));

    assert_pulse_after_normal_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (|entry_pulse_o) |-> ($past(state_o) == 3'd0 && state_o != 3'd0));

    assert_sleep_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd4 && !batt_flt_i && !cfg_swake) |=> (state_o == 3'd4));

    assert_wake_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == 3'd1 || state_o == 3'd2 || state_o == 3'd3) && (|wake_i))
        |=> (state_o == 3'd0));

    assert_standby_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0 && standby_i && !cfg_idle && !reg_we) |=> (state_o == 3'd0));

    assert_flash_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !int_rst_i |-> !flash_rst_o);

endmodule

bind lpc_ctrl lpc_ctrl_checker #(.WAKE_W(WAKE_W)) u_lpc_ctrl_checker (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .standby_i(standby_i),
    .batt_flt_i(batt_flt_i), .wake_i(wake_i), .int_rst_i(int_rst_i),
    .flash_rst_o(flash_rst_o), .state_o(state_o), .entry_pulse_o(entry_pulse_o),
    .cfg_idle(cfg_idle), .cfg_swake(cfg_swake)
);

// File: tb/lpc_ctrl_bench.sv
module lpc_ctrl_bench;

    localparam int ADDR_W = 4;
    localparam int WAKE_W = 3;
    localparam logic [3:0] A_MODE = 4'd0;
    localparam logic [3:0] A_CFG  = 4'd4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_we = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              standby_i = 1'b0;
    logic              batt_flt_i = 1'b0;
    logic [WAKE_W-1:0] wake_i = '0;
    logic              int_rst_i = 1'b0;
    logic              flash_rst_o;
    logic [2:0]        state_o;
    logic [3:0]        entry_pulse_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    lpc_ctrl #(.ADDR_W(ADDR_W), .MODE_ADDR(0), .CFG_ADDR(4), .WAKE_W(WAKE_W)) u_lpc_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .standby_i(standby_i),
        .batt_flt_i(batt_flt_i), .wake_i(wake_i), .int_rst_i(int_rst_i),
        .flash_rst_o(flash_rst_o), .state_o(state_o), .entry_pulse_o(entry_pulse_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // drive at negedge, the edge takes it, return at the next negedge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 state", 32'(state_o), 0);
        chk("R1 pulse", 32'(entry_pulse_o), 0);
        rd(A_MODE, v); chk("R1 mode", v, 0);
        rd(A_CFG, v);  chk("R1 cfg", v, 0);
    endtask

    task automatic t_reserved();
        logic [31:0] v;
        wr(A_CFG, 32'hFFFF_FFFF);
        rd(A_CFG, v); chk("R10 cfg bits", v, 32'h0003_8200);
        wr(A_MODE, 32'hFFFC_1234);
        rd(A_MODE, v); chk("R10 mode bits", v, 32'h0000_1234);
        chk("R3 other pattern no move", 32'(state_o), 0);
        rd(4'd9, v); chk("R10 unmapped addr", v, 0);
        wr(A_CFG, 0);
        wr(A_MODE, 0);
    endtask

    task automatic t_flash();
        int_rst_i = 1'b1; #1;
        chk("R9 flash reset passes", 32'(flash_rst_o), 1);
        wr(A_CFG, 32'h0000_0200);
        chk("R9 flash reset held off", 32'(flash_rst_o), 0);
        int_rst_i = 1'b0;
        wr(A_CFG, 0);
    endtask

    task automatic t_stop();
        logic [31:0] v;
        wake_i = 3'b001; step();
        chk("R8 wake in NORMAL ignored", 32'(state_o), 0);
        wake_i = '0;
        wr(A_MODE, 32'h0001_0000);
        chk("R2 STOP", 32'(state_o), 2);
        chk("R12 STOP pulse", 32'(entry_pulse_o), 32'b0010);
        wr(A_CFG, 32'h0001_0000);
        chk("R12 pulse one cycle", 32'(entry_pulse_o), 0);
        rd(A_CFG, v); chk("R11 cfg write dropped", v, 0);
        wr(A_MODE, 32'h0000_2BED);
        chk("R11 mode write no move", 32'(state_o), 2);
        rd(A_MODE, v); chk("R11 mode kept", v, 32'h0001_0000);
        wake_i = 3'b100; step(); wake_i = '0;
        chk("R8 STOP wake", 32'(state_o), 0);
        rd(A_MODE, v); chk("R8 mode cleared", v, 0);
    endtask

    task automatic t_deep();
        wr(A_CFG, 32'h0001_0000);
        wr(A_MODE, 32'h0001_0000);
        chk("R5 DEEP-STOP", 32'(state_o), 3);
        chk("R12 DEEP pulse", 32'(entry_pulse_o), 32'b0100);
        wake_i = 3'b010; step(); wake_i = '0;
        chk("R8 DEEP wake", 32'(state_o), 0);
        wr(A_CFG, 0);
    endtask

    task automatic t_sleep();
        wr(A_MODE, 32'h0000_2BEC);
        chk("R3 near key no move", 32'(state_o), 0);
        wr(A_MODE, 32'h0000_2BED);
        chk("R3 SLEEP", 32'(state_o), 4);
        chk("R12 SLEEP pulse", 32'(entry_pulse_o), 32'b1000);
        batt_flt_i = 1'b0; wake_i = 3'b111;
        repeat (3) step();
        chk("R7 gated stays asleep", 32'(state_o), 4);
        batt_flt_i = 1'b1; step();
        chk("R7 battery-fault wake", 32'(state_o), 0);
        wake_i = '0; batt_flt_i = 1'b0;
        wr(A_CFG, 32'h0000_8000);
        wr(A_MODE, 32'h0000_2BED);
        chk("R3 SLEEP again", 32'(state_o), 4);
        wake_i = 3'b001; step(); wake_i = '0;
        chk("R7 override wake", 32'(state_o), 0);
        wr(A_CFG, 0);
    endtask

    task automatic t_conflict();
        logic [31:0] v;
        wr(A_MODE, 32'h0000_1234);
        wr(A_MODE, 32'h0001_2BED);
        chk("R4 state", 32'(state_o), 0);
        chk("R4 no pulse", 32'(entry_pulse_o), 0);
        rd(A_MODE, v); chk("R4 mode kept", v, 32'h0000_1234);
        wr(A_MODE, 0);
    endtask

    task automatic t_idle();
        standby_i = 1'b1; repeat (2) step();
        chk("R6 standby ignored", 32'(state_o), 0);
        standby_i = 1'b0;
        wr(A_CFG, 32'h0002_0000);
        standby_i = 1'b1; step(); standby_i = 1'b0;
        chk("R6 IDLE", 32'(state_o), 1);
        chk("R12 IDLE pulse", 32'(entry_pulse_o), 32'b0001);
        step();
        chk("R6 IDLE holds", 32'(state_o), 1);
        wake_i = 3'b100; step(); wake_i = '0;
        chk("R8 IDLE wake", 32'(state_o), 0);
        wr(A_CFG, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset();
        t_reserved();
        t_flash();
        t_stop();
        t_deep();
        t_sleep();
        t_conflict();
        t_idle();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule